// File: doc/BRIEF.md
# System Exception State Registers

This block keeps the pending, active and enable state of eight fixed system exceptions: non-maskable interrupt, deferred service call (PendSV), system tick, memory-management fault, bus fault, usage fault, supervisor call and debug monitor. Hardware sources raise pending state with one-cycle pulses. The core reports each exception as it is taken (activated) and as it returns (deactivated). Software sees and changes the state through two 32-bit registers on a simple register bus.

The interrupt control/state register (offset 0xD04) gives software set and clear bits for some of the exceptions. Its read value is built from live state: the active vector, the highest pending vector and two summary flags for external interrupts, all supplied by the surrounding controller. The handler control/state register (offset 0xD24) shows active, pending and enable bits for the system handlers. Only its three fault enables can be written. Priority arbitration and exception stacking are handled outside this block.

Top module: `sysexc_state_regs`

## Requirements
- R1: After a synchronous active-low reset, all pending, active and enable state is 0, and reads of 0xD04 and 0xD24 return 0.
- R2: A write to 0xD04 with bit 31 set makes NMI pending. A read of 0xD04 shows NMI pending in bit 31.
- R3: In a write to 0xD04, bit 28 sets PendSV pending and bit 27 clears it. When both are 1, PendSV ends up pending. Reads show it in bit 28.
- R4: In a write to 0xD04, bit 26 sets system-tick pending and bit 25 clears it. When both are 1, system tick ends up pending. Reads show it in bit 26.
- R5: A pulse on `hw_set_pend[i]` makes exception i pending. The index order is 0 NMI, 1 PendSV, 2 system tick, 3 memory fault, 4 bus fault, 5 usage fault, 6 supervisor call, 7 debug monitor. A hardware set and a software clear of the same exception in the same cycle leave it pending.
- R6: A pulse on `core_act_set[i]` (same index order) clears pending and sets active for exception i. A set-pending pulse in the same cycle keeps it pending.
- R7: A pulse on `core_act_clr[i]` clears active for exception i, unless `core_act_set[i]` is also high.
- R8: A read of 0xD04 returns these fields. Bits 8:0 hold `cur_vec` when `cur_vld` is high, and 0 otherwise. Bits 20:12 hold `top_pend_vec` when `top_pend_vld` is high, and 0 otherwise. Bit 11 is `ext_act_other` and bit 22 is `ext_pend_any`.
- R9: A read of 0xD24 returns the following bits:
  - Active: memory fault bit 0, bus fault bit 1, usage fault bit 3, supervisor call bit 7, debug monitor bit 8, PendSV bit 10, system tick bit 11.
  - Pending: usage fault bit 12, memory fault bit 13, bus fault bit 14, supervisor call bit 15.
  - Enable: memory fault bit 16, bus fault bit 17, usage fault bit 18.
  - All other bits read 0.
- R10: A write to 0xD24 loads the enables from bits 16, 17 and 18. It changes no pending or active state.
- R11: Reads of any other offset return 0. Writes to any other offset change no state.
- R12: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and shows the state from before that edge. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| hw_set_pend | input | 8 | Set-pending pulses, one per exception |
| core_act_set | input | 8 | Exception taken by the core |
| core_act_clr | input | 8 | Exception returned by the core |
| cur_vld | input | 1 | An exception is active |
| cur_vec | input | 9 | Active vector number |
| top_pend_vld | input | 1 | Some exception is pending |
| top_pend_vec | input | 9 | Highest pending vector number |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| ext_act_other | input | 1 | An external interrupt other than the current one is active |

## Verification
The bench drives each software set bit alone, each clear bit alone, and each set/clear pair written together. This separates set-wins precedence from plain clearing. Hardware pulses that coincide with a software clear or with core activation test the cycle-level precedence that a sequential test would miss. Reads of 0xD04 with the valid flags high and then low show whether the vector fields are gated or passed through raw. An all-ones write to 0xD24, and writes to an unmapped offset, check that only the three enable bits can be written.

// File: rtl/sysexc_pkg.sv
// Package: shared constants for the system exception state registers.
// Assumes a 12-bit byte offset on the register bus.
package sysexc_pkg;
    localparam int NUM_EXC = 8;
    localparam int VEC_W   = 9;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'hD04;
    localparam logic [ADDR_W-1:0] OFS_HND  = 12'hD24;

    typedef enum int {
        EX_NMI  = 0,
        EX_PSV  = 1,
        EX_TICK = 2,
        EX_MEM  = 3,
        EX_BUS  = 4,
        EX_USG  = 5,
        EX_SVC  = 6,
        EX_DBG  = 7
    } exc_idx_e;
endpackage

// File: rtl/sysexc_cell.sv
// Module: state for one exception (pending, active and an optional enable).
// Assumes every input is a one-cycle request. Set requests win over clears.
module sysexc_cell #(
    parameter bit HAS_EN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic act_set_i,
    input  logic act_clr_i,
    input  logic en_we_i,
    input  logic en_val_i,
    output logic pend_o,
    output logic act_o,
    output logic en_o
);
    logic pend_q, act_q;

    // Pending flag: a set wins over a software clear or an activation.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= set_i | (pend_q & ~clr_i & ~act_set_i);
    end

    // Active flag: an activation wins over a deactivation.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_set_i | (act_q & ~act_clr_i);
    end

    generate
        if (HAS_EN) begin : g_en
            logic en_q;
            // Enable flag: loaded only by a handler-register write.
            always_ff @(posedge clk) begin
                if (!rst_n)       en_q <= 1'b0;
                else if (en_we_i) en_q <= en_val_i;
            end
            assign en_o = en_q;

            p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !en_we_i |=> $stable(en_q));
        end else begin : g_no_en
            assign en_o = 1'b0;
        end
    endgenerate

    assign pend_o = pend_q;
    assign act_o  = act_q;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);
    p_activate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_set_i && !set_i) |=> (act_o && !pend_o));
    p_deactivate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_clr_i && !act_set_i) |=> !act_o);
endmodule

// File: rtl/sysexc_wdec.sv
// Module: decodes a register write into per-exception set, clear and enable requests.
// Assumes a write lasts one cycle. Unmapped offsets produce no request.
module sysexc_wdec
    import sysexc_pkg::*;
(
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NUM_EXC-1:0] sw_set_o,
    output logic [NUM_EXC-1:0] sw_clr_o,
    output logic [NUM_EXC-1:0] en_we_o,
    output logic [NUM_EXC-1:0] en_val_o
);
    logic hit_ctrl, hit_hnd;

    // Offset match.
    always_comb begin
        hit_ctrl = wr_i && (addr_i == OFS_CTRL);
        hit_hnd  = wr_i && (addr_i == OFS_HND);
    end

    // Software set/clear pairs, taken from the control/state register.
    always_comb begin
        sw_set_o = '0;
        sw_clr_o = '0;
        sw_set_o[EX_NMI]  = hit_ctrl & wdata_i[31];
        sw_set_o[EX_PSV]  = hit_ctrl & wdata_i[28];
        sw_clr_o[EX_PSV]  = hit_ctrl & wdata_i[27];
        sw_set_o[EX_TICK] = hit_ctrl & wdata_i[26];
        sw_clr_o[EX_TICK] = hit_ctrl & wdata_i[25];
    end

    // Enable writes, taken from the handler register.
    always_comb begin
        en_we_o  = '0;
        en_val_o = '0;
        en_we_o[EX_MEM]  = hit_hnd;
        en_we_o[EX_BUS]  = hit_hnd;
        en_we_o[EX_USG]  = hit_hnd;
        en_val_o[EX_MEM] = wdata_i[16];
        en_val_o[EX_BUS] = wdata_i[17];
        en_val_o[EX_USG] = wdata_i[18];
    end
endmodule

// File: rtl/sysexc_rdmux.sv
// Module: builds read values from live state and registers them on a read strobe.
// Assumes vector numbers are no wider than 9 bits.
module sysexc_rdmux
    import sysexc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_EXC-1:0] pend_i,
    input  logic [NUM_EXC-1:0] act_i,
    input  logic [NUM_EXC-1:0] en_i,
    input  logic               cur_vld_i,
    input  logic [VEC_W-1:0]   cur_vec_i,
    input  logic               top_vld_i,
    input  logic [VEC_W-1:0]   top_vec_i,
    input  logic               ext_pend_i,
    input  logic               ext_act_i,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [DATA_W-1:0] ctrl_val, hnd_val, sel_val;

    // Control/state register value.
    always_comb begin
        ctrl_val = '0;
        if (cur_vld_i) ctrl_val[VEC_W-1:0]     = cur_vec_i;
        if (top_vld_i) ctrl_val[12 +: VEC_W]   = top_vec_i;
        ctrl_val[11] = ext_act_i;
        ctrl_val[22] = ext_pend_i;
        ctrl_val[26] = pend_i[EX_TICK];
        ctrl_val[28] = pend_i[EX_PSV];
        ctrl_val[31] = pend_i[EX_NMI];
    end

    // Handler control/state register value.
    always_comb begin
        hnd_val = '0;
        hnd_val[0]  = act_i[EX_MEM];
        hnd_val[1]  = act_i[EX_BUS];
        hnd_val[3]  = act_i[EX_USG];
        hnd_val[7]  = act_i[EX_SVC];
        hnd_val[8]  = act_i[EX_DBG];
        hnd_val[10] = act_i[EX_PSV];
        hnd_val[11] = act_i[EX_TICK];
        hnd_val[12] = pend_i[EX_USG];
        hnd_val[13] = pend_i[EX_MEM];
        hnd_val[14] = pend_i[EX_BUS];
        hnd_val[15] = pend_i[EX_SVC];
        hnd_val[16] = en_i[EX_MEM];
        hnd_val[17] = en_i[EX_BUS];
        hnd_val[18] = en_i[EX_USG];
    end

    // Offset select. Unmapped offsets read as zero.
    always_comb begin
        case (addr_i)
            OFS_CTRL: sel_val = ctrl_val;
            OFS_HND:  sel_val = hnd_val;
            default:  sel_val = '0;
        endcase
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= sel_val;
    end

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
    p_nmi_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == OFS_CTRL) |=> (rdata_o[31] == $past(pend_i[EX_NMI])));
endmodule

// File: rtl/sysexc_state_regs.sv
// Module: top of the system exception pending/active/enable registers.
// Assumes one register access per cycle and one-cycle event pulses from
// hardware and the core. Priority selection is done elsewhere.
module sysexc_state_regs
    import sysexc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_EXC-1:0]  hw_set_pend,
    input  logic [NUM_EXC-1:0]  core_act_set,
    input  logic [NUM_EXC-1:0]  core_act_clr,
    input  logic                cur_vld,
    input  logic [VEC_W-1:0]    cur_vec,
    input  logic                top_pend_vld,
    input  logic [VEC_W-1:0]    top_pend_vec,
    input  logic                ext_pend_any,
    input  logic                ext_act_other
);
    logic [NUM_EXC-1:0] sw_set, sw_clr, en_we, en_val;
    logic [NUM_EXC-1:0] pend, act, en;

    sysexc_wdec u_wdec (
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .sw_set_o (sw_set),
        .sw_clr_o (sw_clr),
        .en_we_o  (en_we),
        .en_val_o (en_val)
    );

    generate
        for (genvar i = 0; i < NUM_EXC; i++) begin : g_cell
            localparam bit CELL_EN = (i == EX_MEM) || (i == EX_BUS) || (i == EX_USG);
            sysexc_cell #(.HAS_EN(CELL_EN)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_i     (hw_set_pend[i] | sw_set[i]),
                .clr_i     (sw_clr[i]),
                .act_set_i (core_act_set[i]),
                .act_clr_i (core_act_clr[i]),
                .en_we_i   (en_we[i]),
                .en_val_i  (en_val[i]),
                .pend_o    (pend[i]),
                .act_o     (act[i]),
                .en_o      (en[i])
            );
        end
    endgenerate

    sysexc_rdmux u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .pend_i     (pend),
        .act_i      (act),
        .en_i       (en),
        .cur_vld_i  (cur_vld),
        .cur_vec_i  (cur_vec),
        .top_vld_i  (top_pend_vld),
        .top_vec_i  (top_pend_vec),
        .ext_pend_i (ext_pend_any),
        .ext_act_i  (ext_act_other),
        .rdata_o    (bus_rdata)
    );

    p_pair_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[26] && bus_wdata[25]) |=> pend[EX_TICK]);
    p_hnd_write_keeps_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_HND && hw_set_pend == '0 && core_act_set == '0) |=> $stable(pend));
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && act == '0 && en == '0));
endmodule

// File: tb/sysexc_state_regs_tb.sv
// Scoreboard bench. Read tasks queue the expected data; the monitor pops and
// compares one cycle after each read strobe.
module sysexc_state_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  hw_set_pend = '0, core_act_set = '0, core_act_clr = '0;
    logic        cur_vld = 1'b0, top_pend_vld = 1'b0;
    logic [8:0]  cur_vec = '0, top_pend_vec = '0;
    logic        ext_pend_any = 1'b0, ext_act_other = 1'b0;

    int checks = 0;
    int fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sysexc_state_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_set_pend(hw_set_pend), .core_act_set(core_act_set),
        .core_act_clr(core_act_clr), .cur_vld(cur_vld), .cur_vec(cur_vec),
        .top_pend_vld(top_pend_vld), .top_pend_vec(top_pend_vec),
        .ext_pend_any(ext_pend_any), .ext_act_other(ext_act_other)
    );

    always @(posedge clk) rd_d <= bus_rd;

    // Monitor: compare the registered read data with the queued expectation.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [7:0] hw);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; hw_set_pend = hw;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; hw_set_pend = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic core(input logic [7:0] hw, input logic [7:0] s, input logic [7:0] c);
        @(negedge clk);
        hw_set_pend = hw; core_act_set = s; core_act_clr = c;
        @(negedge clk);
        hw_set_pend = '0; core_act_set = '0; core_act_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(12'hD04, 32'h0, "R1 ctrl after reset");
        rd(12'hD24, 32'h0, "R1 handler after reset");
        wr(12'hD04, 32'h8000_0000, 8'h00);
        rd(12'hD04, 32'h8000_0000, "R2 nmi set");
        wr(12'hD04, 32'h1000_0000, 8'h00);
        rd(12'hD04, 32'h9000_0000, "R3 pendsv set");
        wr(12'hD04, 32'h0800_0000, 8'h00);
        rd(12'hD04, 32'h8000_0000, "R3 pendsv clear");
        wr(12'hD04, 32'h1800_0000, 8'h00);
        rd(12'hD04, 32'h9000_0000, "R3 pendsv set wins");
        wr(12'hD04, 32'h0600_0000, 8'h00);
        rd(12'hD04, 32'h9400_0000, "R4 tick set wins");
        wr(12'hD04, 32'h0200_0000, 8'h00);
        rd(12'hD04, 32'h9000_0000, "R4 tick clear");
        wr(12'hD04, 32'h0200_0000, 8'h04);
        rd(12'hD04, 32'h9400_0000, "R5 hw set beats sw clear");
        core(8'h40, 8'h00, 8'h00);
        rd(12'hD24, 32'h0000_8000, "R5 svc hw pending");
        core(8'h00, 8'h40, 8'h00);
        rd(12'hD24, 32'h0000_0080, "R6 svc activated");
        core(8'h00, 8'h00, 8'h40);
        rd(12'hD24, 32'h0, "R7 svc deactivated");
        core(8'h00, 8'h02, 8'h00);
        rd(12'hD04, 32'h8400_0000, "R6 pendsv pending cleared");
        rd(12'hD24, 32'h0000_0400, "R6 pendsv active");
        @(negedge clk);
        cur_vld = 1'b1; cur_vec = 9'd14; top_pend_vld = 1'b1; top_pend_vec = 9'd15;
        ext_pend_any = 1'b1; ext_act_other = 1'b1;
        rd(12'hD04, 32'h8440_F80E, "R8 full composition");
        cur_vld = 1'b0; top_pend_vld = 1'b0;
        rd(12'hD04, 32'h8440_0800, "R8 vectors gated by valid");
        cur_vec = '0; top_pend_vec = '0; ext_pend_any = 1'b0; ext_act_other = 1'b0;
        core(8'h38, 8'h00, 8'h00);
        rd(12'hD24, 32'h0000_7400, "R9 fault pending bits");
        wr(12'hD24, 32'hFFFF_FFFF, 8'h00);
        rd(12'hD24, 32'h0007_7400, "R10 enables written");
        wr(12'hD24, 32'h0, 8'h00);
        rd(12'hD24, 32'h0000_7400, "R10 enables cleared, rest kept");
        core(8'h00, 8'hB8, 8'h00);
        rd(12'hD24, 32'h0000_050B, "R9 active bit positions");
        wr(12'hD08, 32'hFFFF_FFFF, 8'h00);
        rd(12'hD08, 32'h0, "R11 unmapped read");
        rd(12'hD04, 32'h8400_0000, "R11 unmapped write no effect");
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rdata !== 32'h8400_0000) begin
            fails++;
            $display("FAIL R12 hold: actual %h expected %h", bus_rdata, 32'h8400_0000);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule